// File: doc/BRIEF.md
# UART Prioritized Interrupt Controller

This block collects the interrupt causes of a 16550-style serial port with extended flow control and condenses them into one request line and one 6-bit status code. Level causes (line errors, receive FIFO at threshold, modem changes) are reported while their inputs stay active. Event causes are held in sticky flags until serviced: the transmit threshold, character detection, flow-control pin edges and the end of sleep. The software reads the status register and is told only the most urgent pending cause. Lower causes wait in their flags and show up once the urgent one is cleared.

A receive inactivity timer runs inside the block. It counts bit-time ticks while the receive FIFO holds data and nothing moves in or out of it. It raises a timeout once four frame lengths plus twelve bit times have passed. The four upper enable bits work only while the extended-features switch is on.

Top module: `uirq_prio_ctrl`

## Requirements
- R1: After reset, with every enable at 0, `isr_code_o` is 6'h01 (nothing pending) and `irq_o` is 0.
- R2: While `ier_i[2]` is 1 and any bit of `lsr_err_i` (overrun, parity, framing, break) is 1, the code is 6'h06. This cause has the highest priority.
- R3: While `ier_i[0]` is 1 and `rx_trig_i` is 1, the code is 6'h04 unless a more urgent cause is pending.
- R4: While `ier_i[0]` is 1 and `rx_level_i` is non-zero, a run of exactly 4*`frame_bits_i`+12 `bit_tick_i` cycles with no `rx_push_i` or `rd_rhr_i` gives code 6'h0C, and one fewer tick does not. A push or a receive-data read restarts the count and clears the timeout. An empty FIFO never reports a timeout.
- R5: With `ier_i[1]` at 1, a rising edge of (`tx_at_trig_i` or `tx_empty_i`) latches code 6'h02. Enabling `ier_i[1]` while that condition already holds also latches it. A status read that returns 6'h02 clears it.
- R6: While `ier_i[3]` is 1 and any bit of `msr_delta_i` is 1, the code is 6'h00.
- R7: With `ext_en_i` at 0, `ier_i[7:4]` have no effect: character, pin and wakeup events latch nothing and report nothing.
- R8: With `ext_en_i` and `ier_i[5]` at 1, a `char_det_i` pulse latches code 6'h10.
- R9: With `ext_en_i` at 1, a low-to-high edge of `cts_n_i` while `auto_cts_i` is 1 and `ier_i[7]` is 1 latches code 6'h20. The same holds for `rts_n_i` with `auto_rts_i` and `ier_i[6]`. Falling edges, and edges without the auto mode, latch nothing.
- R10: With `ext_en_i` and `ier_i[4]` at 1, a `wake_i` pulse latches code 6'h30.
- R11: Priority from highest to lowest: 06, 0C, 04, 02, 00, 10, 20, 30. A lower cause stays pending while a higher one is reported and appears once the higher one clears.
- R12: A `rd_isr_i` strobe clears only the sticky cause whose code is being returned in that cycle. CTS and RTS edges share code 6'h20 and are cleared together. A read that returns a level cause clears nothing.
- R13: `irq_o` is 1 exactly when bit 0 of `isr_code_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_i | input | 8 | Interrupt enable bits |
| ext_en_i | input | 1 | Extended-features switch that unlocks ier_i[7:4] |
| lsr_err_i | input | 4 | Overrun, parity, framing, break status |
| msr_delta_i | input | 4 | Modem status change bits |
| rx_trig_i | input | 1 | Receive FIFO at or above its threshold |
| rx_level_i | input | RXLVL_W | Receive FIFO fill count |
| rx_push_i | input | 1 | A character entered the receive FIFO |
| rd_rhr_i | input | 1 | Receive data read strobe |
| bit_tick_i | input | 1 | One pulse per bit time |
| frame_bits_i | input | FRAME_W | Bits per frame on the line |
| tx_at_trig_i | input | 1 | Transmit FIFO at or below its threshold |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| char_det_i | input | 1 | Xon/Xoff/special character detected pulse |
| cts_n_i | input | 1 | CTS# pin level |
| rts_n_i | input | 1 | RTS# pin level |
| auto_cts_i | input | 1 | Automatic CTS flow control active |
| auto_rts_i | input | 1 | Automatic RTS flow control active |
| wake_i | input | 1 | Left sleep mode pulse |
| rd_isr_i | input | 1 | Status register read strobe |
| irq_o | output | 1 | Interrupt request |
| isr_code_o | output | 6 | Code of the most urgent pending cause |

## Verification
The hardest state to reach is the exact expiry edge of the receive timeout. The FIFO must stay non-empty and untouched through a precise number of bit ticks. The bench holds the tick high for one tick short of the limit and shows that no timeout appears. It then adds one tick and looks for the timeout code. It also shows that a push partway through restarts the full count. Queued causes are built up by setting a line error, a modem change and a wakeup together. The bench then removes them one at a time and checks that a status read taken while a level cause is reported leaves the wakeup flag in place.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NSRC = 9;
  localparam int CODE_W = 6;

  localparam logic [CODE_W-1:0] C_NONE  = 6'h01;
  localparam logic [CODE_W-1:0] C_LINE  = 6'h06;
  localparam logic [CODE_W-1:0] C_RXTO  = 6'h0C;
  localparam logic [CODE_W-1:0] C_RXDAT = 6'h04;
  localparam logic [CODE_W-1:0] C_TX    = 6'h02;
  localparam logic [CODE_W-1:0] C_MODEM = 6'h00;
  localparam logic [CODE_W-1:0] C_CHAR  = 6'h10;
  localparam logic [CODE_W-1:0] C_FLOW  = 6'h20;
  localparam logic [CODE_W-1:0] C_WAKE  = 6'h30;

  typedef enum logic [3:0] {
    S_LINE = 4'd0, S_RXTO = 4'd1, S_RXDAT = 4'd2, S_TX = 4'd3, S_MODEM = 4'd4,
    S_CHAR = 4'd5, S_CTS = 4'd6, S_RTS = 4'd7, S_WAKE = 4'd8
  } src_idx_e;

  function automatic logic [CODE_W-1:0] code_of(input int idx);
    case (idx)
      0:       code_of = C_LINE;
      1:       code_of = C_RXTO;
      2:       code_of = C_RXDAT;
      3:       code_of = C_TX;
      4:       code_of = C_MODEM;
      5:       code_of = C_CHAR;
      6, 7:    code_of = C_FLOW;
      8:       code_of = C_WAKE;
      default: code_of = C_NONE;
    endcase
  endfunction
endpackage

// File: rtl/uirq_sticky.sv
module uirq_sticky #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic ev_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q, pend_d;
  logic hit;

  generate
    if (EDGE) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= ev_i;
      end
      assign hit = arm_i & ev_i & ~prev_q;
    end else begin : g_level
      assign hit = arm_i & ev_i;
    end
  endgenerate

  always_comb begin
    pend_d = pend_q;
    if (clr_i) pend_d = 1'b0;
    if (hit)   pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/uirq_rx_timer.sv
module uirq_rx_timer #(
  parameter int RXLVL_W = 5,
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RXLVL_W-1:0] rx_level_i,
  input  logic               rx_push_i,
  input  logic               rd_rhr_i,
  input  logic               bit_tick_i,
  input  logic [FRAME_W-1:0] frame_bits_i,
  output logic               expired_o
);
  localparam int CNT_W = FRAME_W + 3;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             exp_q, exp_d;
  logic             nonempty, activity, cnt_en;

  assign limit    = (CNT_W'(frame_bits_i) << 2) + CNT_W'(12);
  assign nonempty = |rx_level_i;
  assign activity = rx_push_i | rd_rhr_i;
  assign cnt_en   = bit_tick_i & ~exp_q;

  always_comb begin
    cnt_d = cnt_q;
    exp_d = exp_q;
    if (!nonempty || activity) begin
      cnt_d = '0;
      exp_d = 1'b0;
    end else if (cnt_en) begin
      if (cnt_q + CNT_W'(1) >= limit) begin
        cnt_d = '0;
        exp_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expired_o = exp_q & nonempty;
endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc
  import uirq_pkg::*;
(
  input  logic [NSRC-1:0]   req_i,
  output logic [CODE_W-1:0] code_o,
  output logic              any_o
);
  always_comb begin
    code_o = C_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) code_o = code_of(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/uirq_prio_ctrl.sv
module uirq_prio_ctrl
  import uirq_pkg::*;
#(
  parameter int RXLVL_W = 5,
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         ier_i,
  input  logic               ext_en_i,
  input  logic [3:0]         lsr_err_i,
  input  logic [3:0]         msr_delta_i,
  input  logic               rx_trig_i,
  input  logic [RXLVL_W-1:0] rx_level_i,
  input  logic               rx_push_i,
  input  logic               rd_rhr_i,
  input  logic               bit_tick_i,
  input  logic [FRAME_W-1:0] frame_bits_i,
  input  logic               tx_at_trig_i,
  input  logic               tx_empty_i,
  input  logic               char_det_i,
  input  logic               cts_n_i,
  input  logic               rts_n_i,
  input  logic               auto_cts_i,
  input  logic               auto_rts_i,
  input  logic               wake_i,
  input  logic               rd_isr_i,
  output logic               irq_o,
  output logic [5:0]         isr_code_o
);
  localparam int NSTK = 5;
  localparam bit [NSTK-1:0] STK_EDGE = 5'b01101;

  logic [NSRC-1:0]   req;
  logic [CODE_W-1:0] code;
  logic              any_req;
  logic              rx_to;
  logic [NSTK-1:0]   stk_arm, stk_ev, stk_clr, stk_pend;
  logic [3:0]        up_en;

  assign up_en = ier_i[7:4] & {4{ext_en_i}};

  uirq_rx_timer #(.RXLVL_W(RXLVL_W), .FRAME_W(FRAME_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .rx_level_i(rx_level_i), .rx_push_i(rx_push_i),
    .rd_rhr_i(rd_rhr_i), .bit_tick_i(bit_tick_i), .frame_bits_i(frame_bits_i),
    .expired_o(rx_to)
  );

  // sticky slots: 0 tx, 1 char, 2 cts, 3 rts, 4 wake
  assign stk_arm = {up_en[0], auto_rts_i & up_en[2], auto_cts_i & up_en[3],
                    up_en[1], 1'b1};
  assign stk_ev  = {wake_i, rts_n_i, cts_n_i, char_det_i,
                    ier_i[1] & (tx_at_trig_i | tx_empty_i)};
  assign stk_clr = {rd_isr_i & (code == C_WAKE),
                    rd_isr_i & (code == C_FLOW),
                    rd_isr_i & (code == C_FLOW),
                    rd_isr_i & (code == C_CHAR),
                    rd_isr_i & (code == C_TX)};

  generate
    for (genvar g = 0; g < NSTK; g++) begin : g_stk
      uirq_sticky #(.EDGE(STK_EDGE[g])) u_stk (
        .clk(clk), .rst_n(rst_n), .arm_i(stk_arm[g]), .ev_i(stk_ev[g]),
        .clr_i(stk_clr[g]), .pend_o(stk_pend[g])
      );
    end
  endgenerate

  always_comb begin
    req          = '0;
    req[S_LINE]  = ier_i[2] & (|lsr_err_i);
    req[S_RXTO]  = ier_i[0] & rx_to;
    req[S_RXDAT] = ier_i[0] & rx_trig_i;
    req[S_TX]    = ier_i[1] & stk_pend[0];
    req[S_MODEM] = ier_i[3] & (|msr_delta_i);
    req[S_CHAR]  = up_en[1] & stk_pend[1];
    req[S_CTS]   = up_en[3] & stk_pend[2];
    req[S_RTS]   = up_en[2] & stk_pend[3];
    req[S_WAKE]  = up_en[0] & stk_pend[4];
  end

  uirq_prio_enc u_enc (.req_i(req), .code_o(code), .any_o(any_req));

  assign isr_code_o = code;
  assign irq_o      = any_req;
endmodule

// File: rtl/uirq_prio_ctrl_chk.sv
module uirq_prio_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ier_i,
  input logic       ext_en_i,
  input logic [3:0] lsr_err_i,
  input logic [3:0] msr_delta_i,
  input logic       wake_i,
  input logic       rd_isr_i,
  input logic       irq_o,
  input logic [5:0] isr_code_o
);
  a_r13_irq_tracks_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == !isr_code_o[0]);

  a_r2_line_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_i[2] && lsr_err_i != 4'd0) |-> isr_code_o == 6'h06);

  a_r7_upper_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en_i |-> (isr_code_o != 6'h10 && isr_code_o != 6'h20 && isr_code_o != 6'h30));

  a_r12_wake_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_isr_i && isr_code_o == 6'h30 && !wake_i) |=> isr_code_o != 6'h30);

  a_r6_modem_blocks_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_i[3] && msr_delta_i != 4'd0) |-> !isr_code_o[0] && isr_code_o[5:4] == 2'b00);
endmodule

bind uirq_prio_ctrl uirq_prio_ctrl_chk u_chk (.*);

// File: tb/uirq_prio_ctrl_bench.sv
module uirq_prio_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] ier_i;
  logic       ext_en_i;
  logic [3:0] lsr_err_i, msr_delta_i;
  logic       rx_trig_i;
  logic [4:0] rx_level_i;
  logic       rx_push_i, rd_rhr_i, bit_tick_i;
  logic [3:0] frame_bits_i;
  logic       tx_at_trig_i, tx_empty_i, char_det_i;
  logic       cts_n_i, rts_n_i, auto_cts_i, auto_rts_i, wake_i, rd_isr_i;
  logic       irq_o;
  logic [5:0] isr_code_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  uirq_prio_ctrl u_uirq_prio_ctrl (.*);

  task automatic chk(input logic [5:0] exp, input string req);
    n_chk++;
    if (isr_code_o !== exp || irq_o !== (exp != 6'h01)) begin
      n_bad++;
      $display("FAIL %s: code=%h irq=%b expected code=%h irq=%b", req,
               isr_code_o, irq_o, exp, exp != 6'h01);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_inputs();
    ier_i = 8'h00; ext_en_i = 1'b0; lsr_err_i = 4'h0; msr_delta_i = 4'h0;
    rx_trig_i = 1'b0; rx_level_i = 5'd0; rx_push_i = 1'b0; rd_rhr_i = 1'b0;
    bit_tick_i = 1'b0; frame_bits_i = 4'd10; tx_at_trig_i = 1'b0;
    tx_empty_i = 1'b0; char_det_i = 1'b0; cts_n_i = 1'b1; rts_n_i = 1'b1;
    auto_cts_i = 1'b0; auto_rts_i = 1'b0; wake_i = 1'b0; rd_isr_i = 1'b0;
  endtask

  task automatic isr_read();
    rd_isr_i = 1'b1; step(); rd_isr_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle_inputs(); step(2); rst_n = 1'b1; step();
    chk(6'h01, "R1 reset idle");
  endtask

  task automatic t_line();
    ier_i = 8'h04; lsr_err_i = 4'b1000; step(); chk(6'h06, "R2 break");
    lsr_err_i = 4'b0001; step(); chk(6'h06, "R2 overrun");
    ier_i = 8'h00; step(); chk(6'h01, "R2 disabled");
    lsr_err_i = 4'h0;
  endtask

  task automatic t_rxdata();
    ier_i = 8'h01; rx_trig_i = 1'b1; rx_level_i = 5'd8; rx_push_i = 1'b1; step();
    rx_push_i = 1'b0; chk(6'h04, "R3 threshold");
    lsr_err_i = 4'b0100; ier_i = 8'h05; step(); chk(6'h06, "R11 line over rx");
    lsr_err_i = 4'h0; rx_trig_i = 1'b0; rx_level_i = 5'd0; ier_i = 8'h00; step();
    chk(6'h01, "R3 below threshold");
  endtask

  task automatic t_timeout();
    ier_i = 8'h01; frame_bits_i = 4'd10; rx_level_i = 5'd3;
    rx_push_i = 1'b1; step(); rx_push_i = 1'b0;
    bit_tick_i = 1'b1; step(51); bit_tick_i = 1'b0; step();
    chk(6'h01, "R4 one tick short");
    bit_tick_i = 1'b1; step(); bit_tick_i = 1'b0; step();
    chk(6'h0C, "R4 expired at 52");
    rd_rhr_i = 1'b1; step(); rd_rhr_i = 1'b0; chk(6'h01, "R4 read clears");
    bit_tick_i = 1'b1; step(30); bit_tick_i = 1'b0;
    rx_push_i = 1'b1; step(); rx_push_i = 1'b0;
    bit_tick_i = 1'b1; step(51); bit_tick_i = 1'b0; step();
    chk(6'h01, "R4 push restarts");
    bit_tick_i = 1'b1; step(); bit_tick_i = 1'b0; step();
    chk(6'h0C, "R4 expired after restart");
    rx_level_i = 5'd0; step(); chk(6'h01, "R4 empty no timeout");
    ier_i = 8'h00;
  endtask

  task automatic t_tx();
    ier_i = 8'h02; tx_empty_i = 1'b1; step(); step(); chk(6'h02, "R5 empty edge");
    isr_read(); chk(6'h01, "R5 read clears");
    tx_empty_i = 1'b0; step(); tx_at_trig_i = 1'b1; step(); step();
    chk(6'h02, "R5 threshold edge");
    isr_read(); ier_i = 8'h00; step(); ier_i = 8'h02; step(); step();
    chk(6'h02, "R5 enable with condition");
    isr_read(); tx_at_trig_i = 1'b0; ier_i = 8'h00; step();
  endtask

  task automatic t_modem();
    ier_i = 8'h08; msr_delta_i = 4'b0100; step(); chk(6'h00, "R6 ring edge");
    msr_delta_i = 4'h0; step(); chk(6'h01, "R6 cleared");
  endtask

  task automatic t_ext_gate();
    ier_i = 8'hF0; ext_en_i = 1'b0; auto_cts_i = 1'b1; auto_rts_i = 1'b1;
    char_det_i = 1'b1; wake_i = 1'b1; cts_n_i = 1'b0; rts_n_i = 1'b0; step();
    char_det_i = 1'b0; wake_i = 1'b0; cts_n_i = 1'b1; rts_n_i = 1'b1; step();
    chk(6'h01, "R7 locked events");
    ext_en_i = 1'b1; step(); chk(6'h01, "R7 nothing latched while locked");
    ext_en_i = 1'b0; auto_cts_i = 1'b0; auto_rts_i = 1'b0; ier_i = 8'h00;
  endtask

  task automatic t_char();
    ext_en_i = 1'b1; ier_i = 8'h20; char_det_i = 1'b1; step(); char_det_i = 1'b0;
    chk(6'h10, "R8 char pulse");
    isr_read(); chk(6'h01, "R8 read clears");
  endtask

  task automatic t_flow();
    ier_i = 8'hC0;
    cts_n_i = 1'b0; step(); cts_n_i = 1'b1; step(); chk(6'h01, "R9 no auto");
    auto_cts_i = 1'b1; cts_n_i = 1'b0; step(); chk(6'h01, "R9 falling ignored");
    cts_n_i = 1'b1; step(); chk(6'h20, "R9 cts rise");
    auto_rts_i = 1'b1; rts_n_i = 1'b0; step(); rts_n_i = 1'b1; step();
    isr_read(); chk(6'h01, "R12 shared code clears both");
    auto_cts_i = 1'b0; auto_rts_i = 1'b0; ier_i = 8'h00;
  endtask

  task automatic t_queue();
    ier_i = 8'h1C; lsr_err_i = 4'b0010; msr_delta_i = 4'b0001;
    wake_i = 1'b1; step(); wake_i = 1'b0; chk(6'h06, "R11 line first");
    lsr_err_i = 4'h0; step(); chk(6'h00, "R11 modem next");
    isr_read(); msr_delta_i = 4'h0; step(); chk(6'h30, "R12 wake kept, R10 wake");
    isr_read(); chk(6'h01, "R12 wake cleared");
    ier_i = 8'h00; ext_en_i = 1'b0;
  endtask

  initial begin
    t_reset();
    t_line();
    t_rxdata();
    t_timeout();
    t_tx();
    t_modem();
    t_ext_gate();
    t_char();
    t_flow();
    t_queue();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule